// File: doc/BRIEF.md
# Effective Address Generator

This block forms the operand address for the memory-reference instructions of a 32-bit load/store machine. It takes an instruction word, the program counter (already advanced past that instruction) and a combinational read port into the register file. From these it works out which of six forms the instruction is. It then adds the right base and the right sign-extended constant, and registers the result together with the destination register number and two flags that tell the memory stage whether to read, write, or stay idle.

There are two address families. The displacement family adds a sign-extended 17-bit constant to a base register. A zero base field means "no base" rather than register 0, so the constant alone becomes the address. The relative family adds a sign-extended 22-bit constant to the PC. In each family the load-address variant leaves memory idle, and the computed address is the value that will be written to the destination register.

The register-file read index is driven straight from the instruction and is not registered. All results appear one clock after the instruction is presented. A parameter selects one shared adder with muxed operands or two dedicated adders with a result mux.

Top module: `ea_gen`

## Requirements
- R1: `rf_raddr` always equals instruction bits 21..17 in the same cycle, whatever the opcode.
- R2: For a displacement form (opcode 1, 3 or 5) whose bits 21..17 are zero, the address is bits 16..0 sign-extended from bit 16, and the register-file data has no effect on it.
- R3: For a displacement form with a nonzero bits 21..17, the address is `rf_rdata` plus bits 16..0 sign-extended from bit 16.
- R4: For a relative form (opcode 2, 4 or 6), the address is `pc` plus bits 21..0 sign-extended from bit 21, and `rf_rdata` has no effect on it.
- R5: Opcode (bits 31..27) 1 and 2 give `out_mem_en`=1, `out_mem_wr`=0. Opcode 3 and 4 give `out_mem_en`=1, `out_mem_wr`=1. Opcode 5 and 6 give `out_mem_en`=0, `out_mem_wr`=0.
- R6: An opcode outside 1..6, or `in_valid`=0, gives `out_valid`=0 on the next cycle.
- R7: `out_dest` equals instruction bits 26..22 of the accepted instruction.
- R8: Outputs appear exactly one clock after `in_valid` is sampled high. While `rst_n` is low, `out_valid` is 0.
- R9: All additions wrap modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and PC are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Program counter, already advanced |
| rf_raddr | output | 5 | Register-file read index (base field) |
| rf_rdata | input | 32 | Register-file read data for `rf_raddr` |
| out_valid | output | 1 | Registered result is valid |
| out_addr | output | 32 | Effective address, or load-address value |
| out_mem_en | output | 1 | Memory is accessed |
| out_mem_wr | output | 1 | Access is a write |
| out_dest | output | 5 | Register named by bits 26..22 |

## Verification
Two functions meet in one cycle on the relative forms: the base-register read and the PC-relative addition. The upper bits of the 22-bit constant occupy the base field, so a relative instruction always drives a nonzero read index while its address must ignore the data that comes back. The bench issues relative instructions whose constant has all-ones upper bits, with the register model returning distinctive nonzero data. It judges the result against `pc` plus the sign-extended constant alone. In the same way, displacement instructions with a zero base field are issued while the model returns nonzero data for index 0, which confirms that this data is never added.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

   localparam int unsigned OPC_LD  = 1;
   localparam int unsigned OPC_LDR = 2;
   localparam int unsigned OPC_ST  = 3;
   localparam int unsigned OPC_STR = 4;
   localparam int unsigned OPC_LA  = 5;
   localparam int unsigned OPC_LAR = 6;

   typedef struct packed {
      logic legal;
      logic mem_en;
      logic mem_wr;
      logic use_pc;
      logic use_base;
   } ea_ctl_t;

endpackage

// File: rtl/ea_decode.sv
module ea_decode
   import ea_gen_pkg::*;
#(
   parameter int OPW  = 5,
   parameter int RIDX = 5
) (
   input  logic [OPW-1:0]  op,
   input  logic [RIDX-1:0] base_idx,
   output ea_ctl_t         ctl
);

   logic is_disp;
   logic is_rel;

   always_comb begin
      ctl     = '0;
      is_disp = 1'b0;
      is_rel  = 1'b0;
      unique case (op)
         OPW'(OPC_LD):  begin is_disp = 1'b1; ctl.mem_en = 1'b1; end
         OPW'(OPC_ST):  begin is_disp = 1'b1; ctl.mem_en = 1'b1; ctl.mem_wr = 1'b1; end
         OPW'(OPC_LA):  begin is_disp = 1'b1; end
         OPW'(OPC_LDR): begin is_rel  = 1'b1; ctl.mem_en = 1'b1; end
         OPW'(OPC_STR): begin is_rel  = 1'b1; ctl.mem_en = 1'b1; ctl.mem_wr = 1'b1; end
         OPW'(OPC_LAR): begin is_rel  = 1'b1; end
         default:       ;
      endcase
      ctl.legal    = is_disp | is_rel;
      ctl.use_pc   = is_rel;
      // a zero base field selects "no base", never register 0
      ctl.use_base = is_disp & (base_idx != '0);
   end

endmodule

// File: rtl/ea_sum.sv
module ea_sum
   import ea_gen_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int C1W    = 22,
   parameter int C2W    = 17,
   parameter bit SHARED = 1'b1
) (
   input  ea_ctl_t         ctl,
   input  logic [C1W-1:0]  c_rel,
   input  logic [C2W-1:0]  c_disp,
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] sum
);

   localparam int EXT1 = XLEN - C1W;
   localparam int EXT2 = XLEN - C2W;

   logic [XLEN-1:0] rel_off;
   logic [XLEN-1:0] disp_off;
   logic [XLEN-1:0] base_gated;

   assign rel_off    = {{EXT1{c_rel[C1W-1]}}, c_rel};
   assign disp_off   = {{EXT2{c_disp[C2W-1]}}, c_disp};
   assign base_gated = ctl.use_base ? base : '0;

   generate
      if (SHARED) begin : g_shared
         logic [XLEN-1:0] opa;
         logic [XLEN-1:0] opb;
         assign opa = ctl.use_pc ? pc      : base_gated;
         assign opb = ctl.use_pc ? rel_off : disp_off;
         assign sum = opa + opb;
      end else begin : g_split
         logic [XLEN-1:0] disp_sum;
         logic [XLEN-1:0] rel_sum;
         assign disp_sum = base_gated + disp_off;
         assign rel_sum  = pc + rel_off;
         assign sum      = ctl.use_pc ? rel_sum : disp_sum;
      end
   endgenerate

endmodule

// File: rtl/ea_oreg.sv
module ea_oreg #(
   parameter int XLEN = 32,
   parameter int RIDX = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            d_valid,
   input  logic [XLEN-1:0] d_addr,
   input  logic            d_mem_en,
   input  logic            d_mem_wr,
   input  logic [RIDX-1:0] d_dest,
   output logic            q_valid,
   output logic [XLEN-1:0] q_addr,
   output logic            q_mem_en,
   output logic            q_mem_wr,
   output logic [RIDX-1:0] q_dest
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid  <= 1'b0;
         q_addr   <= '0;
         q_mem_en <= 1'b0;
         q_mem_wr <= 1'b0;
         q_dest   <= '0;
      end else begin
         q_valid  <= d_valid;
         q_addr   <= d_addr;
         q_mem_en <= d_valid & d_mem_en;
         q_mem_wr <= d_valid & d_mem_wr;
         q_dest   <= d_dest;
      end
   end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int OPW          = 5,
   parameter int RIDX         = 5,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XLEN-1:0] instr,
   input  logic [XLEN-1:0] pc,
   output logic [RIDX-1:0] rf_raddr,
   input  logic [XLEN-1:0] rf_rdata,
   output logic            out_valid,
   output logic [XLEN-1:0] out_addr,
   output logic            out_mem_en,
   output logic            out_mem_wr,
   output logic [RIDX-1:0] out_dest
);

   localparam int OP_LSB = XLEN - OPW;
   localparam int RA_LSB = OP_LSB - RIDX;
   localparam int RB_LSB = RA_LSB - RIDX;
   localparam int C1W    = RA_LSB;
   localparam int C2W    = RB_LSB;

   generate
      if (OPW < 3) begin : g_bad_opw
         $error("ea_gen: OPW must hold opcodes up to 6");
      end
      if (RB_LSB < 2) begin : g_bad_fields
         $error("ea_gen: XLEN too small for opcode and two register fields");
      end
   endgenerate

   logic [OPW-1:0]  f_op;
   logic [RIDX-1:0] f_ra;
   logic [RIDX-1:0] f_rb;
   logic [C1W-1:0]  f_c1;
   logic [C2W-1:0]  f_c2;
   ea_ctl_t         ctl;
   logic [XLEN-1:0] sum;

   assign f_op = instr[XLEN-1:OP_LSB];
   assign f_ra = instr[OP_LSB-1:RA_LSB];
   assign f_rb = instr[RA_LSB-1:RB_LSB];
   assign f_c1 = instr[C1W-1:0];
   assign f_c2 = instr[C2W-1:0];

   assign rf_raddr = f_rb;

   ea_decode #(.OPW(OPW), .RIDX(RIDX)) u_dec (
      .op       (f_op),
      .base_idx (f_rb),
      .ctl      (ctl)
   );

   ea_sum #(.XLEN(XLEN), .C1W(C1W), .C2W(C2W), .SHARED(SHARED_ADDER)) u_sum (
      .ctl    (ctl),
      .c_rel  (f_c1),
      .c_disp (f_c2),
      .base   (rf_rdata),
      .pc     (pc),
      .sum    (sum)
   );

   ea_oreg #(.XLEN(XLEN), .RIDX(RIDX)) u_oreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_valid  (in_valid & ctl.legal),
      .d_addr   (sum),
      .d_mem_en (ctl.mem_en),
      .d_mem_wr (ctl.mem_wr),
      .d_dest   (f_ra),
      .q_valid  (out_valid),
      .q_addr   (out_addr),
      .q_mem_en (out_mem_en),
      .q_mem_wr (out_mem_wr),
      .q_dest   (out_dest)
   );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int XLEN = 32,
   parameter int OPW  = 5,
   parameter int RIDX = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [XLEN-1:0] instr,
   input logic [XLEN-1:0] pc,
   input logic            out_valid,
   input logic [XLEN-1:0] out_addr,
   input logic            out_mem_en,
   input logic            out_mem_wr,
   input logic [RIDX-1:0] out_dest
);

   localparam int OP_LSB = XLEN - OPW;
   localparam int RA_LSB = OP_LSB - RIDX;
   localparam int RB_LSB = RA_LSB - RIDX;

   logic [OPW-1:0]  op;
   logic            is_disp;
   logic            is_rel;
   logic            is_la;
   logic            nobase;
   logic [XLEN-1:0] exp_rel;
   logic [XLEN-1:0] exp_nobase;

   assign op         = instr[XLEN-1:OP_LSB];
   assign is_disp    = (op == OPW'(1)) || (op == OPW'(3)) || (op == OPW'(5));
   assign is_rel     = (op == OPW'(2)) || (op == OPW'(4)) || (op == OPW'(6));
   assign is_la      = (op == OPW'(5)) || (op == OPW'(6));
   assign nobase     = instr[RA_LSB-1:RB_LSB] == '0;
   assign exp_rel    = pc + XLEN'($signed(instr[RA_LSB-1:0]));
   assign exp_nobase = XLEN'($signed(instr[RB_LSB-1:0]));

   assert_out_needs_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_bad_op_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_disp && !is_rel) |=> !out_valid);

   assert_write_is_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem_wr |-> out_mem_en);

   assert_load_addr_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_la) |=> (out_valid && !out_mem_en));

   assert_dest_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (is_disp || is_rel)) |=> out_dest == $past(instr[OP_LSB-1:RA_LSB]));

   assert_rel_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_rel) |=> out_addr == $past(exp_rel));

   assert_no_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_disp && nobase) |=> out_addr == $past(exp_nobase));

endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN), .OPW(OPW), .RIDX(RIDX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .instr      (instr),
   .pc         (pc),
   .out_valid  (out_valid),
   .out_addr   (out_addr),
   .out_mem_en (out_mem_en),
   .out_mem_wr (out_mem_wr),
   .out_dest   (out_dest)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] pc = '0;
   logic [4:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        out_valid;
   logic [31:0] out_addr;
   logic        out_mem_en;
   logic        out_mem_wr;
   logic [4:0]  out_dest;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [31:0] rf_val(input logic [4:0] idx);
      if (idx == 5'd31) return 32'hFFFF_FFF0;
      return {idx, 27'h0} | 32'h0000_4000;
   endfunction

   always_comb rf_rdata = rf_val(rf_raddr);

   ea_gen u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .out_valid(out_valid),
      .out_addr(out_addr), .out_mem_en(out_mem_en), .out_mem_wr(out_mem_wr),
      .out_dest(out_dest)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int op, input int ra, input int rb,
                                      input logic [16:0] c2);
      return {op[4:0], ra[4:0], rb[4:0], c2};
   endfunction

   function automatic logic [31:0] mkr(input int op, input int ra, input logic [21:0] c1);
      return {op[4:0], ra[4:0], c1};
   endfunction

   // present one instruction, sample one clock later, then idle
   task automatic issue(input logic [31:0] w, input logic [31:0] p);
      @(negedge clk);
      in_valid = 1'b1;
      instr    = w;
      pc       = p;
      #1;
      check("R1", "read index", 32'(rf_raddr), 32'(w[21:17]));
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic [31:0] addr,
                             input logic en, input logic wr, input logic [4:0] dest);
      check("R8", "valid", 32'(out_valid), 32'd1);
      check(req, "address", out_addr, addr);
      check("R5", "mem_en", 32'(out_mem_en), 32'(en));
      check("R5", "mem_wr", 32'(out_mem_wr), 32'(wr));
      check("R7", "dest", 32'(out_dest), 32'(dest));
   endtask

   task automatic t_reset();
      #1;
      check("R8", "valid in reset", 32'(out_valid), 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R8", "valid after reset", 32'(out_valid), 32'd0);
   endtask

   task automatic t_no_base();
      issue(mk(1, 3, 0, 17'h1FFF0), 32'h0000_1000);
      expect_out("R2", 32'hFFFF_FFF0, 1'b1, 1'b0, 5'd3);
      issue(mk(5, 9, 0, 17'h0ABCD), 32'h0000_1000);
      expect_out("R2", 32'h0000_ABCD, 1'b0, 1'b0, 5'd9);
   endtask

   task automatic t_with_base();
      issue(mk(3, 4, 5, 17'h00010), 32'h0);
      expect_out("R3", rf_val(5'd5) + 32'h10, 1'b1, 1'b1, 5'd4);
      issue(mk(1, 30, 2, 17'h1FFFF), 32'h0);
      expect_out("R3", rf_val(5'd2) - 32'h1, 1'b1, 1'b0, 5'd30);
   endtask

   task automatic t_wrap();
      issue(mk(5, 1, 31, 17'h00020), 32'h0);
      expect_out("R9", 32'h0000_0010, 1'b0, 1'b0, 5'd1);
      issue(mkr(6, 2, 22'h000010), 32'hFFFF_FFF8);
      expect_out("R9", 32'h0000_0008, 1'b0, 1'b0, 5'd2);
   endtask

   task automatic t_relative();
      issue(mkr(2, 7, 22'h3FFFFC), 32'h0000_0100);
      expect_out("R4", 32'h0000_00FC, 1'b1, 1'b0, 5'd7);
      issue(mkr(4, 8, 22'h1FFFFF), 32'h0000_0100);
      expect_out("R4", 32'h0020_00FF, 1'b1, 1'b1, 5'd8);
      issue(mkr(6, 31, 22'h200000), 32'h1000_0000);
      expect_out("R4", 32'h0FE0_0000, 1'b0, 1'b0, 5'd31);
   endtask

   task automatic t_illegal();
      int codes[4] = '{0, 7, 8, 31};
      foreach (codes[i]) begin
         issue(mk(codes[i], 3, 4, 17'h5), 32'h0);
         check("R6", "valid for illegal op", 32'(out_valid), 32'd0);
         check("R6", "mem_en for illegal op", 32'(out_mem_en), 32'd0);
      end
   endtask

   task automatic t_idle();
      issue(mk(1, 3, 4, 17'h5), 32'h0);
      check("R8", "valid one cycle later", 32'(out_valid), 32'd1);
      @(posedge clk);
      #1;
      check("R6", "valid with in_valid low", 32'(out_valid), 32'd0);
   endtask

   initial begin
      t_reset();
      t_no_base();
      t_with_base();
      t_wrap();
      t_relative();
      t_illegal();
      t_idle();
      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule